// File: doc/BRIEF.md
# Counter/Timer Bus Programming Interface

This block is the processor-facing register port of a four-channel counter/timer. It watches a multiplexed I/O bus made of an active-low chip enable, an active-low I/O request, an active-low read line, an active-low opcode-fetch line and a two-bit channel select. The bus has no write line, so a write is inferred when an I/O cycle is addressed to the block while the read line is inactive.

Every written byte is sorted into one of three kinds: a channel control word, a time constant, or the shared interrupt vector. It then goes to the addressed channel as a one-cycle load strobe with the byte alongside, or into the vector register. The sorting depends on the byte's lowest bit and on a per-channel flag. That flag is raised by a control word that announces a time constant and is cleared when that constant arrives. The block also keeps a per-channel ready flag, which shows that a channel holds a time constant and may run.

A read cycle returns the live down-count of the selected channel, taken combinationally from the channel datapaths. The channel datapaths are not part of this block.

Top module: `ctc_bus_if`

## Requirements
- R1: The channel select picks the channel by its binary value (00 channel 0, 01 channel 1, 10 channel 2, 11 channel 3). A write strobe appears only on the selected channel's bit.
- R2: A write is chip enable low, I/O request low, read high and opcode-fetch high. It yields exactly one strobe, high for one cycle in the clock cycle after the first rising edge at which the write condition is sampled. Holding the bus cycle longer produces no further strobe.
- R3: When the addressed channel is not expecting a time constant, a byte with bit 0 = 1 is a control word. It pulses that channel's `ctrl_we` bit, and `wdata` carries the byte.
- R4: A control word with bit 2 = 1 sets that channel's `tc_pending`. The next byte written to that channel, whatever its bit 0, pulses `tc_we` for that channel and clears `tc_pending`. A control word with bit 2 = 0 clears `tc_pending`.
- R5: When channel 0 is not expecting a time constant, a byte with bit 0 = 0 written to channel 0 is a vector. It pulses `vec_we` and stores bits 7:3 in `vec_base`. The same byte written to channel 1, 2 or 3 is ignored: no strobe, and `vec_base` is unchanged.
- R6: `chan_ready` for a channel is set by a time constant write to it. It is cleared by a control word to it with bit 1 = 1 (software reset). No other event sets it.
- R7: During a read (chip enable, I/O request and read low, opcode-fetch high), `dout_en` is 1 and `dout` equals the selected channel's 8-bit count, where channel n occupies `cnt_flat[8n+7:8n]`. At all other times `dout_en` is 0. A read causes no strobe and changes no flag.
- R8: A cycle with opcode-fetch and I/O request both low (an interrupt acknowledge) causes no write strobe, no flag change and no `dout_en`.
- R9: While `rst_n` is low, all strobes, `tc_pending`, `chan_ready`, `vec_base` and `dout_en` are 0. After reset, every channel needs a new control word and time constant before it becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, held for at least three clocks |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low; high during an I/O cycle means write |
| m1_n | input | 1 | Opcode-fetch marker, active low; low with I/O request marks an acknowledge |
| csel | input | 2 | Channel select |
| din | input | 8 | Write data from the processor |
| cnt_flat | input | 32 | Live down-counts of the four channels, 8 bits each |
| dout | output | 8 | Read data: count of the selected channel |
| dout_en | output | 1 | Bus drive enable, high only during a valid read |
| ctrl_we | output | 4 | Per-channel control word strobe |
| tc_we | output | 4 | Per-channel time constant strobe |
| vec_we | output | 1 | Vector register strobe |
| wdata | output | 8 | Byte that accompanies a strobe |
| tc_pending | output | 4 | Per-channel flag: next byte is a time constant |
| chan_ready | output | 4 | Per-channel flag: time constant held, channel may run |
| vec_base | output | 5 | Upper five vector bits |

## Verification
The assertions assume that the bus inputs change away from the rising clock edge and that `rst_n` is low from time zero. The one-strobe-per-cycle checks also assume that a write cycle releases chip enable or I/O request for at least one clock before the next write begins. The bench drives every bus field on the falling edge and returns the bus to idle for a cycle between transactions. Random writes, reads and acknowledge cycles therefore never overlap, and a mid-run reset is applied only while the bus is idle.

// File: rtl/ctc_bus_pkg.sv
`timescale 1ns/1ps
package ctc_bus_pkg;
  localparam int BYTE_W     = 8;
  localparam int KIND_BIT   = 0;  // 1 = control word
  localparam int SWRST_BIT  = 1;  // software reset of the channel
  localparam int TCNEXT_BIT = 2;  // a time constant follows
  localparam int VEC_LSB    = 3;  // lowest user-supplied vector bit
  localparam int VEC_W      = BYTE_W - VEC_LSB;

  typedef enum logic [1:0] {WK_NONE, WK_CTRL, WK_TCONST, WK_VECTOR} word_kind_e;

  // Sort a written byte by the channel's expectation and its lowest bit.
  function automatic word_kind_e classify_word(input logic tc_due, input logic to_ch0,
                                               input logic [BYTE_W-1:0] b);
    if (tc_due)       return WK_TCONST;
    if (b[KIND_BIT])  return WK_CTRL;
    if (to_ch0)       return WK_VECTOR;
    return WK_NONE;
  endfunction
endpackage

// File: rtl/ctc_cycle_decode.sv
`timescale 1ns/1ps
module ctc_cycle_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic m1_n,
  output logic wr_pulse,
  output logic rd_active
);
  logic io_cycle;
  logic wr_cond;
  logic wr_cond_q;

  // An acknowledge (opcode-fetch low) is never a data cycle.
  assign io_cycle  = rst_n && !ce_n && !iorq_n && m1_n;
  assign wr_cond   = io_cycle && rd_n;
  assign rd_active = io_cycle && !rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_cond_q <= 1'b0;
    else        wr_cond_q <= wr_cond;
  end

  assign wr_pulse = wr_cond && !wr_cond_q;
endmodule

// File: rtl/ctc_word_router.sv
`timescale 1ns/1ps
module ctc_word_router
  import ctc_bus_pkg::*;
#(
  parameter int NCH = 4,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [SW-1:0]     csel,
  input  logic [BYTE_W-1:0] din,
  output logic [NCH-1:0]    ctrl_we,
  output logic [NCH-1:0]    tc_we,
  output logic              vec_we,
  output logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    tc_pending,
  output logic [NCH-1:0]    chan_ready,
  output logic [VEC_W-1:0]  vec_base
);
  logic [NCH-1:0] hit;
  always_comb begin
    hit = '0;
    if (wr_pulse) hit[csel] = 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    word_kind_e kind;
    logic ctrl_q, tc_q, pend_q, rdy_q;

    assign kind = classify_word(pend_q, (i == 0), din);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q <= 1'b0;
        tc_q   <= 1'b0;
        pend_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else begin
        ctrl_q <= hit[i] && (kind == WK_CTRL);
        tc_q   <= hit[i] && (kind == WK_TCONST);
        if (hit[i] && kind == WK_CTRL) begin
          pend_q <= din[TCNEXT_BIT];
          if (din[SWRST_BIT]) rdy_q <= 1'b0;
        end else if (hit[i] && kind == WK_TCONST) begin
          pend_q <= 1'b0;
          rdy_q  <= 1'b1;
        end
      end
    end

    assign ctrl_we[i]    = ctrl_q;
    assign tc_we[i]      = tc_q;
    assign tc_pending[i] = pend_q;
    assign chan_ready[i] = rdy_q;
  end

  logic vec_hit;
  assign vec_hit = hit[0] && (classify_word(tc_pending[0], 1'b1, din) == WK_VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_we   <= 1'b0;
      vec_base <= '0;
      wdata    <= '0;
    end else begin
      vec_we <= vec_hit;
      if (vec_hit)  vec_base <= din[BYTE_W-1:VEC_LSB];
      if (wr_pulse) wdata    <= din;
    end
  end
endmodule

// File: rtl/ctc_read_mux.sv
`timescale 1ns/1ps
module ctc_read_mux
  import ctc_bus_pkg::*;
#(
  parameter int NCH = 4,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*BYTE_W-1:0] cnt_flat,
  input  logic [SW-1:0]         csel,
  input  logic                  rd_active,
  output logic [BYTE_W-1:0]     dout,
  output logic                  dout_en
);
  logic [BYTE_W-1:0] cnt_arr [NCH];
  for (genvar i = 0; i < NCH; i++) begin : g_unpack
    assign cnt_arr[i] = cnt_flat[i*BYTE_W +: BYTE_W];
  end

  assign dout_en = rd_active;
  assign dout    = rd_active ? cnt_arr[csel] : '0;
endmodule

// File: rtl/ctc_bus_if.sv
`timescale 1ns/1ps
module ctc_bus_if
  import ctc_bus_pkg::*;
#(
  parameter int NCH = 4,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  iorq_n,
  input  logic                  rd_n,
  input  logic                  m1_n,
  input  logic [SW-1:0]         csel,
  input  logic [BYTE_W-1:0]     din,
  input  logic [NCH*BYTE_W-1:0] cnt_flat,
  output logic [BYTE_W-1:0]     dout,
  output logic                  dout_en,
  output logic [NCH-1:0]        ctrl_we,
  output logic [NCH-1:0]        tc_we,
  output logic                  vec_we,
  output logic [BYTE_W-1:0]     wdata,
  output logic [NCH-1:0]        tc_pending,
  output logic [NCH-1:0]        chan_ready,
  output logic [VEC_W-1:0]      vec_base
);
  logic wr_pulse;
  logic rd_active;

  ctc_cycle_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n),
    .wr_pulse(wr_pulse), .rd_active(rd_active)
  );

  ctc_word_router #(.NCH(NCH)) u_rt (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .csel(csel), .din(din),
    .ctrl_we(ctrl_we), .tc_we(tc_we), .vec_we(vec_we), .wdata(wdata),
    .tc_pending(tc_pending), .chan_ready(chan_ready), .vec_base(vec_base)
  );

  ctc_read_mux #(.NCH(NCH)) u_rd (
    .cnt_flat(cnt_flat), .csel(csel), .rd_active(rd_active), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/ctc_bus_if_chk.sv
`timescale 1ns/1ps
module ctc_bus_if_chk
  import ctc_bus_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_n,
  input logic               iorq_n,
  input logic               rd_n,
  input logic               m1_n,
  input logic               dout_en,
  input logic [NCH-1:0]     ctrl_we,
  input logic [NCH-1:0]     tc_we,
  input logic               vec_we,
  input logic [NCH-1:0]     tc_pending,
  input logic [NCH-1:0]     chan_ready,
  input logic [VEC_W-1:0]   vec_base
);
  logic any_wr;
  assign any_wr = |{ctrl_we, tc_we, vec_we};

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_we, tc_we, vec_we}) <= 1);

  // R2
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> !any_wr);

  // R4
  tc_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_we) |-> ((tc_we & $past(tc_pending)) == tc_we));

  // R6
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_ready & ~$past(chan_ready)) & ~tc_we) == '0);

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_base) |-> vec_we);

  // R7
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !iorq_n && !rd_n && m1_n));

  // R8
  inta_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && !iorq_n) |=> !any_wr);
endmodule

bind ctc_bus_if ctc_bus_if_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n),
  .dout_en(dout_en), .ctrl_we(ctrl_we), .tc_we(tc_we), .vec_we(vec_we),
  .tc_pending(tc_pending), .chan_ready(chan_ready), .vec_base(vec_base)
);

// File: tb/sim_ctc_bus_if.sv
`timescale 1ns/1ps
module sim_ctc_bus_if;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
  logic [1:0]  csel = '0;
  logic [7:0]  din = '0;
  logic [31:0] cnt_flat = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic [3:0]  ctrl_we, tc_we, tc_pending, chan_ready;
  logic        vec_we;
  logic [7:0]  wdata;
  logic [4:0]  vec_base;

  always #5 clk = ~clk;

  ctc_bus_if #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n),
    .csel(csel), .din(din), .cnt_flat(cnt_flat), .dout(dout), .dout_en(dout_en),
    .ctrl_we(ctrl_we), .tc_we(tc_we), .vec_we(vec_we), .wdata(wdata),
    .tc_pending(tc_pending), .chan_ready(chan_ready), .vec_base(vec_base)
  );

  int  tests = 0, fails = 0;
  bit  done = 1'b0;
  logic [3:0] m_pend = '0, m_rdy = '0;
  logic [4:0] m_vec = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 ignored, 1 control, 2 time constant, 3 vector
  function automatic int kind_of(input int ch, input logic [7:0] b);
    if (m_pend[ch]) return 2;
    if (b[0] == 1'b1) return 1;
    return (ch == 0) ? 3 : 0;
  endfunction

  task automatic idle_bus();
    ce_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
  endtask

  task automatic do_write(input int ch, input logic [7:0] b);
    int k;
    logic [3:0] one;
    k = kind_of(ch, b);
    one = 4'b0001 << ch;
    @(negedge clk);
    ce_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b1; m1_n = 1'b1; csel = 2'(ch); din = b;
    @(negedge clk);
    case (k)
      1: begin m_pend[ch] = b[2]; if (b[1]) m_rdy[ch] = 1'b0; end
      2: begin m_pend[ch] = 1'b0; m_rdy[ch] = 1'b1; end
      3: m_vec = b[7:3];
      default: ;
    endcase
    chk(ctrl_we == ((k == 1) ? one : 4'b0), "R1 R3 control strobe", 32'(ctrl_we), 32'((k == 1) ? one : 4'b0));
    chk(tc_we == ((k == 2) ? one : 4'b0), "R1 R4 time constant strobe", 32'(tc_we), 32'((k == 2) ? one : 4'b0));
    chk(vec_we == (k == 3), "R5 vector strobe", 32'(vec_we), 32'(k == 3));
    if (k != 0) chk(wdata == b, "R3 write data", 32'(wdata), 32'(b));
    chk(tc_pending == m_pend, "R4 pending flags", 32'(tc_pending), 32'(m_pend));
    chk(chan_ready == m_rdy, "R6 ready flags", 32'(chan_ready), 32'(m_rdy));
    chk(vec_base == m_vec, "R5 vector base", 32'(vec_base), 32'(m_vec));
    @(negedge clk);
    chk({ctrl_we, tc_we, vec_we} == 9'b0, "R2 held cycle writes once", 32'({ctrl_we, tc_we, vec_we}), 0);
    idle_bus();
  endtask

  task automatic do_read(input int ch);
    logic [7:0] exp;
    @(negedge clk);
    cnt_flat = $urandom;
    ce_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b1; csel = 2'(ch);
    exp = 8'((cnt_flat >> (8 * ch)) & 32'hFF);
    #1;
    chk(dout_en == 1'b1, "R7 drive enable in read", 32'(dout_en), 1);
    chk(dout == exp, "R7 read count", 32'(dout), 32'(exp));
    @(negedge clk);
    chk({ctrl_we, tc_we, vec_we} == 9'b0 && tc_pending == m_pend && chan_ready == m_rdy,
        "R7 read writes nothing", 32'({tc_pending, chan_ready}), 32'({m_pend, m_rdy}));
    idle_bus();
    #1;
    chk(dout_en == 1'b0, "R7 bus released", 32'(dout_en), 0);
  endtask

  task automatic do_inta();
    @(negedge clk);
    ce_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b1; m1_n = 1'b0;
    csel = 2'($urandom % 4); din = 8'($urandom);
    @(negedge clk);
    chk({ctrl_we, tc_we, vec_we} == 9'b0 && dout_en == 1'b0, "R8 acknowledge no strobe",
        32'({ctrl_we, tc_we, vec_we, dout_en}), 0);
    chk(tc_pending == m_pend && vec_base == m_vec, "R8 acknowledge keeps state",
        32'({tc_pending, vec_base}), 32'({m_pend, m_vec}));
    idle_bus();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_pend = '0; m_rdy = '0; m_vec = '0;
    repeat (4) @(negedge clk);
    chk({ctrl_we, tc_we, vec_we, tc_pending, chan_ready, vec_base, dout_en} == '0,
        "R9 reset state", 32'({tc_pending, chan_ready, vec_base}), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 R3 R4 R6 directed: program every channel
    for (int c = 0; c < NCH; c++) begin
      do_write(c, 8'h85);
      do_write(c, 8'(8'h10 + c));
    end
    // R4 time constant with bit 0 = 0 and = 1
    do_write(2, 8'h05);
    do_write(2, 8'h00);
    do_write(1, 8'h05);
    do_write(1, 8'h33);
    // R5 vector on channel 0, ignored on channel 3
    do_write(0, 8'hA8);
    do_write(3, 8'h50);
    // R6 software reset clears ready, no constant follows
    do_write(3, 8'h03);
    // R7 reads on all channels
    for (int c = 0; c < NCH; c++) do_read(c);
    do_inta();
    // R9 mid-run reset, then an even byte to channel 1 must be ignored
    do_reset();
    do_write(1, 8'h44);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 6)      do_write(int'($urandom % 4), 8'($urandom));
      else if (r < 8) do_read(int'($urandom % 4));
      else if (r < 9) do_inta();
      else            do_write(int'($urandom % 4), 8'($urandom) | 8'h05);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule